// File: doc/BRIEF.md
# Nearest Space Vector Selector

This block serves the modulation stage of a multilevel converter. Each control period it receives three signed fixed-point phase voltage references, already scaled so that one unit is one cell voltage. It returns the integer vector, in line-to-line coordinates ab, bc and ca, that lies nearest to the reference. The result can go to a later stage that turns it into cell counts. The datapath has no table and no oblique coordinate system. It does not depend on how many cells the converter has: only the input width limits the reach.

The block takes the three phase differences and rounds each one to the nearest integer. It then adds up the rounded values. A zero sum means the rounded triple is already a valid vector. A sum of plus or minus one means the reference lies inside an upright or an inverted triangle of the vector lattice. In that case three candidates are formed, each by removing the sum from one coordinate. The block scores each candidate by a signed rounding residue and keeps the candidate with the largest score.

A one-cycle `start` strobe captures the references. Two clock edges later a one-cycle `done` strobe presents the result. A new `start` may arrive every cycle.

Top module: `nearest_vec_sel`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and all three output coordinates are 0.
- R2: When `start` is sampled high at one rising edge, `done` is high for exactly one cycle after the second rising edge that follows. Starts on consecutive cycles each give their own result in order.
- R3: Only the differences a−b, b−c and c−a matter. Adding the same offset to all three references leaves the result unchanged.
- R4: Each difference, in Q8.8 (8 fractional bits), is rounded to the nearest integer. An exact half is rounded away from zero, so +0.5 becomes +1 and −0.5 becomes −1.
- R5: When the three rounded values sum to zero, the output equals the rounded triple.
- R6: When the sum s is +1 or −1, the score of each axis is s times (rounded value − exact difference). The output equals the rounded triple with s subtracted from the coordinate of the axis that has the largest score: ab, bc or ca.
- R7: When scores tie for the largest, ab wins over bc, and bc wins over ca.
- R8: The output coordinates always sum to zero.
- R9: No integer triple that sums to zero has a smaller sum of squared errors against the exact differences than the output has.
- R10: Between `done` pulses, the output coordinates hold their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe for the three references |
| ref_a | input | IN_W (16) | Phase a reference, signed, FRAC (8) fractional bits |
| ref_b | input | IN_W (16) | Phase b reference, signed, FRAC (8) fractional bits |
| ref_c | input | IN_W (16) | Phase c reference, signed, FRAC (8) fractional bits |
| done | output | 1 | One-cycle result strobe |
| vec_ab | output | IN_W-FRAC+3 (11) | Selected ab coordinate, signed integer |
| vec_bc | output | IN_W-FRAC+3 (11) | Selected bc coordinate, signed integer |
| vec_ca | output | IN_W-FRAC+3 (11) | Selected ca coordinate, signed integer |

## Verification
A wrong residue or a wrong sign on the triangle test does not always show as an invalid vector. It usually shows as a valid lattice point one step away from the true nearest one. For this reason every result is scored against an exhaustive search of nearby lattice points, on the same `done` pulse that presents it. A fault in the rounding or in the candidate arithmetic shows up at once as a nonzero coordinate sum, or as an error larger than the minimum. A pipeline or enable fault shows up as a strobe that comes a cycle off, or as outputs that drift while the block is idle. The exact tie and half-way patterns are driven on purpose, because random references almost never hit them.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // which candidate the selector settled on
  typedef enum logic [1:0] {
    SEL_ROUND = 2'd0,
    SEL_AB    = 2'd1,
    SEL_BC    = 2'd2,
    SEL_CA    = 2'd3
  } nvs_sel_e;

  localparam int unsigned NAX = 3;  // ab, bc, ca

endpackage

// File: rtl/nvs_round.sv
// Rounds one line-to-line value to an integer (half away from zero) and
// reports the residue (rounded - exact) in fractional units.
module nvs_round #(
  parameter int LL_W  = 17,
  parameter int FRAC  = 8,
  parameter int INT_W = LL_W + 1 - FRAC,
  parameter int E_W   = FRAC + 2
) (
  input  logic signed [LL_W-1:0]  u_in,
  output logic signed [INT_W-1:0] c_out,
  output logic signed [E_W-1:0]   e_out
);

  localparam logic [LL_W:0] HALF = (LL_W+1)'(1) << (FRAC - 1);

  logic signed [LL_W:0] ext;
  logic        [LL_W:0] bias;
  logic signed [LL_W:0] biased;

  always_comb begin
    ext    = {u_in[LL_W-1], u_in};
    bias   = u_in[LL_W-1] ? (HALF - 1'b1) : HALF;
    biased = ext + $signed(bias);
    // integer part of the biased value is the rounded result
    c_out  = biased[LL_W:FRAC];
    // rounded*2^F - u = bias - fractional remainder
    e_out  = $signed({2'b00, bias[FRAC-1:0]}) - $signed({2'b00, biased[FRAC-1:0]});
  end

endmodule

// File: rtl/nvs_pick.sv
// Detects the triangle case from the sum of rounded values and chooses
// among the three neighbouring candidates.
module nvs_pick
  import nvs_pkg::*;
#(
  parameter int INT_W = 10,
  parameter int E_W   = 10,
  parameter int OUT_W = INT_W + 1
) (
  input  logic signed [INT_W-1:0] c_in [NAX],
  input  logic signed [E_W-1:0]   e_in [NAX],
  output logic signed [OUT_W-1:0] n_out [NAX]
);

  localparam int S_W = INT_W + 2;

  logic signed [S_W-1:0]   sig_sum;
  logic                    sig_nz;
  logic                    sig_neg;
  logic signed [E_W-1:0]   score [NAX];
  logic signed [OUT_W-1:0] step;
  nvs_sel_e                sel;
  logic [NAX-1:0]          pick_oh;

  always_comb begin
    sig_sum = '0;
    for (int i = 0; i < NAX; i++) begin
      sig_sum = sig_sum + S_W'(c_in[i]);
    end
    sig_nz  = |sig_sum;
    sig_neg = sig_sum[S_W-1];
    step    = sig_neg ? '1 : OUT_W'(1);
  end

  for (genvar g = 0; g < NAX; g++) begin : g_score
    assign score[g] = sig_neg ? -e_in[g] : e_in[g];
  end

  always_comb begin
    if (!sig_nz) begin
      sel = SEL_ROUND;
    end else if (score[0] >= score[1] && score[0] >= score[2]) begin
      sel = SEL_AB;
    end else if (score[1] >= score[2]) begin
      sel = SEL_BC;
    end else begin
      sel = SEL_CA;
    end
    unique case (sel)
      SEL_AB:  pick_oh = 3'b001;
      SEL_BC:  pick_oh = 3'b010;
      SEL_CA:  pick_oh = 3'b100;
      default: pick_oh = 3'b000;
    endcase
  end

  for (genvar g = 0; g < NAX; g++) begin : g_out
    assign n_out[g] = OUT_W'(c_in[g]) - (pick_oh[g] ? step : OUT_W'(0));
  end

endmodule

// File: rtl/nearest_vec_sel.sv
module nearest_vec_sel
  import nvs_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int FRAC = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic signed [IN_W-1:0]           ref_a,
  input  logic signed [IN_W-1:0]           ref_b,
  input  logic signed [IN_W-1:0]           ref_c,
  output logic                             done,
  output logic signed [IN_W-FRAC+2:0]      vec_ab,
  output logic signed [IN_W-FRAC+2:0]      vec_bc,
  output logic signed [IN_W-FRAC+2:0]      vec_ca
);

  localparam int LL_W  = IN_W + 1;
  localparam int INT_W = LL_W + 1 - FRAC;
  localparam int E_W   = FRAC + 2;
  localparam int OUT_W = INT_W + 1;

  // stage 0: line-to-line differences
  logic signed [LL_W-1:0]  ll [NAX];
  logic signed [INT_W-1:0] rnd_d [NAX];
  logic signed [E_W-1:0]   res_d [NAX];

  always_comb begin
    ll[0] = LL_W'(ref_a) - LL_W'(ref_b);
    ll[1] = LL_W'(ref_b) - LL_W'(ref_c);
    ll[2] = LL_W'(ref_c) - LL_W'(ref_a);
  end

  for (genvar g = 0; g < NAX; g++) begin : g_rnd
    nvs_round #(.LL_W(LL_W), .FRAC(FRAC), .INT_W(INT_W), .E_W(E_W)) u_rnd (
      .u_in  (ll[g]),
      .c_out (rnd_d[g]),
      .e_out (res_d[g])
    );
  end

  // stage 1 registers
  logic signed [INT_W-1:0] rnd_q [NAX];
  logic signed [E_W-1:0]   res_q [NAX];
  logic                    v1_q;
  logic signed [INT_W-1:0] rnd_n [NAX];
  logic signed [E_W-1:0]   res_n [NAX];

  always_comb begin
    for (int i = 0; i < NAX; i++) begin
      rnd_n[i] = start ? rnd_d[i] : rnd_q[i];
      res_n[i] = start ? res_d[i] : res_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      for (int i = 0; i < NAX; i++) begin
        rnd_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      v1_q <= start;
      for (int i = 0; i < NAX; i++) begin
        rnd_q[i] <= rnd_n[i];
        res_q[i] <= res_n[i];
      end
    end
  end

  // stage 2: candidate choice and output registers
  logic signed [OUT_W-1:0] pick_d [NAX];
  logic signed [OUT_W-1:0] vec_q  [NAX];
  logic signed [OUT_W-1:0] vec_n  [NAX];
  logic                    done_q;

  nvs_pick #(.INT_W(INT_W), .E_W(E_W), .OUT_W(OUT_W)) u_pick (
    .c_in  (rnd_q),
    .e_in  (res_q),
    .n_out (pick_d)
  );

  always_comb begin
    for (int i = 0; i < NAX; i++) begin
      vec_n[i] = v1_q ? pick_d[i] : vec_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      for (int i = 0; i < NAX; i++) begin
        vec_q[i] <= '0;
      end
    end else begin
      done_q <= v1_q;
      for (int i = 0; i < NAX; i++) begin
        vec_q[i] <= vec_n[i];
      end
    end
  end

  assign done   = done_q;
  assign vec_ab = vec_q[0];
  assign vec_bc = vec_q[1];
  assign vec_ca = vec_q[2];

endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
  parameter int IN_W = 16,
  parameter int FRAC = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic signed [IN_W-1:0]      ref_a,
  input logic signed [IN_W-1:0]      ref_b,
  input logic signed [IN_W-1:0]      ref_c,
  input logic                        done,
  input logic signed [IN_W-FRAC+2:0] vec_ab,
  input logic signed [IN_W-FRAC+2:0] vec_bc,
  input logic signed [IN_W-FRAC+2:0] vec_ca
);

  localparam int SCALE = 2 ** FRAC;
  localparam int LIM   = 3 * SCALE / 2;

  function automatic int abs_i(input int x);
    return (x < 0) ? -x : x;
  endfunction

  int lab, lbc, vsum;
  always_comb begin
    lab  = int'(ref_a) - int'(ref_b);
    lbc  = int'(ref_b) - int'(ref_c);
    vsum = int'(vec_ab) + int'(vec_bc) + int'(vec_ca);
  end

  // R2: result strobe two edges after the capture strobe
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);
  a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));
  // R8: valid vector
  a_r8_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vsum == 0));
  // R9: each coordinate stays within one and a half cells of the reference
  a_r9_near_ref: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (abs_i(int'(vec_ab) * SCALE - $past(lab, 2)) <= LIM &&
              abs_i(int'(vec_bc) * SCALE - $past(lbc, 2)) <= LIM));
  // R10: outputs hold between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({vec_ab, vec_bc, vec_ca}));

endmodule

bind nearest_vec_sel nvs_chk #(.IN_W(IN_W), .FRAC(FRAC)) u_nvs_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .ref_a  (ref_a),
  .ref_b  (ref_b),
  .ref_c  (ref_c),
  .done   (done),
  .vec_ab (vec_ab),
  .vec_bc (vec_bc),
  .vec_ca (vec_ca)
);

// File: tb/tb_nearest_vec_sel.sv
module tb_nearest_vec_sel;

  localparam int IN_W = 16;
  localparam int FRAC = 8;
  localparam int OW   = IN_W - FRAC + 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic signed [IN_W-1:0] ref_a, ref_b, ref_c;
  logic done;
  logic signed [OW-1:0] vec_ab, vec_bc, vec_ca;

  nearest_vec_sel #(.IN_W(IN_W), .FRAC(FRAC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .done(done), .vec_ab(vec_ab), .vec_bc(vec_bc), .vec_ca(vec_ca)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    a, b, c;
    bit    exact;
    int    xab, xbc, xca;
    int    cyc;
    string tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sq_err(input int nab, input int nbc, input int nca,
                                    input int uab, input int ubc, input int uca);
    longint dab, dbc, dca;
    dab = longint'(nab) * 256 - uab;
    dbc = longint'(nbc) * 256 - ubc;
    dca = longint'(nca) * 256 - uca;
    return dab * dab + dbc * dbc + dca * dca;
  endfunction

  function automatic longint brute_min(input int uab, input int ubc, input int uca);
    longint best;
    best = -1;
    for (int i = uab / 256 - 3; i <= uab / 256 + 3; i++) begin
      for (int j = ubc / 256 - 3; j <= ubc / 256 + 3; j++) begin
        longint e;
        e = sq_err(i, j, -i - j, uab, ubc, uca);
        if (best < 0 || e < best) best = e;
      end
    end
    return best;
  endfunction

  task automatic send(input int a, input int b, input int c, input bit exact,
                      input int xab, input int xbc, input int xca, input string tag);
    item_t it;
    @(negedge clk);
    ref_a = IN_W'(a);
    ref_b = IN_W'(b);
    ref_c = IN_W'(c);
    start = 1'b1;
    it.a = a; it.b = b; it.c = c; it.exact = exact;
    it.xab = xab; it.xbc = xbc; it.xca = xca; it.cyc = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done && !ended) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected done", 1, 0);
      end else begin
        item_t it;
        int uab, ubc, uca;
        longint e_dut, e_min;
        it  = sb.pop_front();
        uab = it.a - it.b;
        ubc = it.b - it.c;
        uca = it.c - it.a;
        check(cyc == it.cyc + 2, "R2", "done cycle", cyc, it.cyc + 2);
        check(int'(vec_ab) + int'(vec_bc) + int'(vec_ca) == 0, "R8", "coord sum",
              int'(vec_ab) + int'(vec_bc) + int'(vec_ca), 0);
        e_dut = sq_err(int'(vec_ab), int'(vec_bc), int'(vec_ca), uab, ubc, uca);
        e_min = brute_min(uab, ubc, uca);
        check(e_dut == e_min, "R9", "squared error", e_dut, e_min);
        if (it.exact) begin
          check(int'(vec_ab) == it.xab, it.tag, "vec_ab", vec_ab, it.xab);
          check(int'(vec_bc) == it.xbc, it.tag, "vec_bc", vec_bc, it.xbc);
          check(int'(vec_ca) == it.xca, it.tag, "vec_ca", vec_ca, it.xca);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !ended) begin
      ended = 1'b1;
      check(1'b0, "WATCHDOG", "run timed out", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h_ab, h_bc, h_ca;
    rst_n = 1'b0;
    start = 1'b0;
    ref_a = '0; ref_b = '0; ref_c = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(vec_ab == 0 && vec_bc == 0 && vec_ca == 0, "R1", "vec in reset",
          int'(vec_ab) + int'(vec_bc) * 1000, 0);
    rst_n = 1'b1;
    idle(2);

    // R6: triangle case, sum +1, ab candidate wins
    send(410, 13, -422, 1'b1, 1, 2, -3, "R6");
    // R6: mirrored, sum -1
    send(-410, -13, 422, 1'b1, -1, -2, 3, "R6");
    // R3: common offset added to all phases
    send(410 + 768, 13 + 768, -422 + 768, 1'b1, 1, 2, -3, "R3");
    send(1000, 1000, 1000, 1'b1, 0, 0, 0, "R3");
    // R5: rounded triple already valid
    send(300, 0, -300, 1'b1, 1, 1, -2, "R5");
    // R4: exact halves rounded away from zero
    send(128, 0, -128, 1'b1, 0, 1, -1, "R4");
    send(-128, 0, 128, 1'b1, 0, -1, 1, "R4");
    // R4/R5: extremes of the input range
    send(32767, -32768, 0, 1'b1, 256, -128, -128, "R4");
    // R7: tie ordering
    send(160, 0, -160, 1'b1, 0, 1, -1, "R7");
    send(-320, 0, -160, 1'b1, -1, 0, 1, "R7");
    send(160, 0, 320, 1'b1, 0, -1, 1, "R7");
    idle(4);

    // R9: random references, back-to-back and spaced
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 4095)) - 2048, 1'b0, 0, 0, 0, "R9");
      if (n % 7 == 0) idle(1 + n % 3);
    end
    idle(5);
    check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);

    // R10: inputs change without a start, outputs must hold
    h_ab = int'(vec_ab); h_bc = int'(vec_bc); h_ca = int'(vec_ca);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ref_a = IN_W'(int'($urandom_range(0, 4095)) - 2048);
      ref_b = IN_W'(int'($urandom_range(0, 4095)) - 2048);
      ref_c = IN_W'(int'($urandom_range(0, 4095)) - 2048);
      check(done == 1'b0, "R10", "done while idle", done, 0);
      check(int'(vec_ab) == h_ab && int'(vec_bc) == h_bc && int'(vec_ca) == h_ca,
            "R10", "vec_ab held", vec_ab, h_ab);
    end

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule